// File: doc/BRIEF.md
# Receive Subaddress Ping-Pong Buffer Controller

This block manages a pair of equal data blocks in shared RAM for one receive or broadcast subaddress of a serial-bus remote terminal. It holds the subaddress lookup pointer. Bit 5 of that pointer selects which of the two 32-word blocks is active, meaning it is the block that the next incoming message fills.

While a message is in progress, the block produces the RAM word address for each received data word. When a valid receive message ends and the subaddress is in double-buffer mode, the block inverts the block-select bit of the pointer. After that, the block that has just been filled is the inactive one, and the host can read it safely.

The host loads the pointer while the bus side is idle. The pointer can be read back at any time. The host can stop swaps by switching the subaddress to single-message mode. In that mode the block that holds the latest valid data is found by inverting bit 5 of the pointer that was read back.

Top module: `sa_pingpong_ctrl`

## Requirements
- R1: After reset, `ptr_rd` is 0, `msg_busy` is 0 and `word_addr` is 0.
- R2: When the block is idle and `msg_start` is low, a cycle with `host_ptr_we` high loads `host_ptr_wdata` into the pointer. The new value is seen on `ptr_rd` from the next cycle.
- R3: During a message, `word_addr` is the pointer with its low five bits replaced by the word index. The index is 0 after message start and rises by one for each cycle in which `word_strobe` is high.
- R4: The word index stops at 31, so a message of more than 32 words keeps addressing the last word of the block.
- R5: A message that began with `host_mode` = 2'b10 (double buffer) and with `msg_rx` = 1, and that ends with `msg_valid` = 1, inverts pointer bit 5. The result is seen on `ptr_rd` in the cycle after `msg_end`. No other pointer bit changes.
- R6: A message that ends with `msg_valid` = 0 leaves the pointer unchanged.
- R7: A message that began with `msg_rx` = 0 (transmit) leaves the pointer unchanged in every mode.
- R8: The mode codes 2'b00 (single message), 2'b01 (circular) and 2'b11 (reserved, treated as single message) never change the pointer.
- R9: `host_mode` and `msg_rx` are sampled only in the cycle of `msg_start`. A change to either during a message has no effect on that message.
- R10: A host pointer write during a message is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 2 | Buffering mode of the subaddress (00 single, 01 circular, 10 double, 11 as single) |
| host_ptr_we | input | 1 | Host pointer write strobe |
| host_ptr_wdata | input | PTR_W | Pointer value written by the host |
| msg_start | input | 1 | Start of a message to this subaddress |
| msg_rx | input | 1 | 1 for a receive or broadcast message, 0 for transmit |
| word_strobe | input | 1 | One data word transferred at the current address |
| msg_end | input | 1 | End of the message |
| msg_valid | input | 1 | Message completed without error, qualifies `msg_end` |
| ptr_rd | output | PTR_W | Current lookup pointer, for host reads |
| word_addr | output | PTR_W | RAM address of the current data word |
| msg_busy | output | 1 | A message is in progress |

## Verification
The assertions take for granted that `msg_start` arrives only when `msg_busy` is low, and that `msg_end` arrives only when it is high. They also assume that a start is never raised together with a host write. The bench keeps to this by driving every message as start, a run of strobes, then one end cycle. Host loads are issued only between messages, apart from the single deliberate write during a message that tests R10. Every combination of mode code, direction and validity is swept, with word counts from 0 to past 32. The expected pointer and addresses are computed arithmetically from the requirements.

// File: rtl/sa_pp_pkg.sv
package sa_pp_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_CIRC   = 2'b01,
        MODE_DBL    = 2'b10,
        MODE_RSVD   = 2'b11
    } sa_mode_e;
endpackage

// File: rtl/sa_mode_decode.sv
module sa_mode_decode
    import sa_pp_pkg::*;
(
    input  logic [1:0] mode_i,
    output logic       dbl_o
);
    sa_mode_e mode;
    always_comb begin
        mode  = sa_mode_e'(mode_i);
        // only the double-buffer code arms the swap; reserved acts as single
        dbl_o = (mode == MODE_DBL);
    end
endmodule

// File: rtl/sa_word_index.sv
module sa_word_index #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] idx
);
    localparam logic [W-1:0] LAST = '1;

    logic [W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr) begin
            idx_d = '0;
        end else if (inc && (idx_q != LAST)) begin
            idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;
endmodule

// File: rtl/sa_pingpong_ctrl.sv
module sa_pingpong_ctrl #(
    parameter int PTR_W = 16,
    parameter int BLK_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       host_mode,
    input  logic             host_ptr_we,
    input  logic [PTR_W-1:0] host_ptr_wdata,
    input  logic             msg_start,
    input  logic             msg_rx,
    input  logic             word_strobe,
    input  logic             msg_end,
    input  logic             msg_valid,
    output logic [PTR_W-1:0] ptr_rd,
    output logic [PTR_W-1:0] word_addr,
    output logic             msg_busy
);
    // block select bit sits just above the word index
    localparam int SWAP_BIT = BLK_W;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             busy;
        logic             dbl;
        logic             rx;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             mode_dbl;
    logic             start_ok;
    logic [BLK_W-1:0] widx;

    sa_mode_decode u_dec (
        .mode_i (host_mode),
        .dbl_o  (mode_dbl)
    );

    assign start_ok = msg_start && !st_q.busy;

    sa_word_index #(.W(BLK_W)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_ok),
        .inc   (st_q.busy && word_strobe),
        .idx   (widx)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (msg_start) begin
                st_d.busy = 1'b1;
                st_d.dbl  = mode_dbl;
                st_d.rx   = msg_rx;
            end else if (host_ptr_we) begin
                st_d.ptr  = host_ptr_wdata;
            end
        end else if (msg_end) begin
            st_d.busy = 1'b0;
            if (msg_valid && st_q.dbl && st_q.rx) begin
                st_d.ptr[SWAP_BIT] = ~st_q.ptr[SWAP_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_rd    = st_q.ptr;
    assign msg_busy  = st_q.busy;
    assign word_addr = {st_q.ptr[PTR_W-1:BLK_W], widx};

    // plain views of latched state for the bound checker
    logic lat_dbl, lat_rx;
    assign lat_dbl = st_q.dbl;
    assign lat_rx  = st_q.rx;
endmodule

// File: rtl/sa_pingpong_chk.sv
module sa_pingpong_chk #(
    parameter int PTR_W = 16,
    parameter int BLK_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_ptr_we,
    input logic             word_strobe,
    input logic             msg_end,
    input logic             msg_valid,
    input logic             busy,
    input logic             lat_dbl,
    input logic             lat_rx,
    input logic [PTR_W-1:0] ptr,
    input logic [PTR_W-1:0] word_addr
);
    localparam logic [PTR_W-1:0] SWAP_MASK = PTR_W'(1) << BLK_W;
    localparam logic [BLK_W-1:0] LAST      = '1;

    AST_SWAP_ON_VALID_RX: assert property (@(posedge clk) disable iff (!rst_n)
        busy && msg_end && msg_valid && lat_dbl && lat_rx |=> ptr == ($past(ptr) ^ SWAP_MASK)); // R5
    AST_HOLD_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        busy && msg_end && !msg_valid |=> $stable(ptr)); // R6
    AST_HOLD_ON_TX: assert property (@(posedge clk) disable iff (!rst_n)
        busy && msg_end && !lat_rx |=> $stable(ptr)); // R7
    AST_HOLD_OTHER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && msg_end && !lat_dbl |=> $stable(ptr)); // R8
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !msg_end |=> $stable(lat_dbl) && $stable(lat_rx)); // R9
    AST_HOST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && host_ptr_we && !msg_end |=> $stable(ptr)); // R10
    AST_WORD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !msg_end && word_strobe && (word_addr[BLK_W-1:0] != LAST)
        |=> word_addr == $past(word_addr) + 1'b1); // R3
    AST_WORD_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !msg_end && (word_addr[BLK_W-1:0] == LAST) |=> $stable(word_addr)); // R4
endmodule

bind sa_pingpong_ctrl sa_pingpong_chk #(.PTR_W(PTR_W), .BLK_W(BLK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ptr_we (host_ptr_we),
    .word_strobe (word_strobe),
    .msg_end     (msg_end),
    .msg_valid   (msg_valid),
    .busy        (msg_busy),
    .lat_dbl     (lat_dbl),
    .lat_rx      (lat_rx),
    .ptr         (ptr_rd),
    .word_addr   (word_addr)
);

// File: tb/tb_sa_pingpong_ctrl.sv
`timescale 1ns/1ps
module tb_sa_pingpong_ctrl;
    localparam int PTR_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       host_mode = 2'b00;
    logic             host_ptr_we = 1'b0;
    logic [PTR_W-1:0] host_ptr_wdata = '0;
    logic             msg_start = 1'b0;
    logic             msg_rx = 1'b0;
    logic             word_strobe = 1'b0;
    logic             msg_end = 1'b0;
    logic             msg_valid = 1'b0;
    logic [PTR_W-1:0] ptr_rd, word_addr;
    logic             msg_busy;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [PTR_W-1:0] exp_ptr;

    always #10 clk = ~clk;

    sa_pingpong_ctrl dut (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
        .host_ptr_we(host_ptr_we), .host_ptr_wdata(host_ptr_wdata),
        .msg_start(msg_start), .msg_rx(msg_rx), .word_strobe(word_strobe),
        .msg_end(msg_end), .msg_valid(msg_valid),
        .ptr_rd(ptr_rd), .word_addr(word_addr), .msg_busy(msg_busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_load(input logic [PTR_W-1:0] v);
        @(negedge clk);
        host_ptr_we = 1'b1; host_ptr_wdata = v;
        @(negedge clk);
        host_ptr_we = 1'b0;
        exp_ptr = v;
        check("R2 host load", 32'(ptr_rd), 32'(v));
    endtask

    // one message: mode at start, mode after start, direction, validity, words, host write mid-message
    task automatic run_msg(input logic [1:0] m0, input logic [1:0] m1, input bit rx,
                           input bit v, input int n, input bit hw);
        int lim;
        @(negedge clk);
        msg_start = 1'b1; host_mode = m0; msg_rx = rx;
        @(negedge clk);
        msg_start = 1'b0; host_mode = m1; msg_rx = ~rx;
        check("R3 busy after start", 32'(msg_busy), 32'd1);
        if (hw) begin
            host_ptr_we = 1'b1; host_ptr_wdata = ~exp_ptr;
            @(negedge clk);
            host_ptr_we = 1'b0;
            check("R10 write ignored mid-message", 32'(ptr_rd), 32'(exp_ptr));
        end
        for (int i = 0; i < n; i++) begin
            lim = (i > 31) ? 31 : i;
            check((i > 31) ? "R4 saturated addr" : "R3 word addr",
                  32'(word_addr), 32'((exp_ptr & 16'hFFE0) | PTR_W'(lim)));
            word_strobe = 1'b1;
            @(negedge clk);
            word_strobe = 1'b0;
        end
        lim = (n > 31) ? 31 : n;
        check((n > 31) ? "R4 final addr" : "R3 final addr",
              32'(word_addr), 32'((exp_ptr & 16'hFFE0) | PTR_W'(lim)));
        msg_end = 1'b1; msg_valid = v;
        @(negedge clk);
        msg_end = 1'b0; msg_valid = 1'b0;
        if (m0 == 2'b10 && rx && v) exp_ptr = exp_ptr ^ 16'h0020;
        if (!v)                      check("R6 ptr after msg", 32'(ptr_rd), 32'(exp_ptr));
        else if (!rx)                check("R7 ptr after msg", 32'(ptr_rd), 32'(exp_ptr));
        else if (m0 != 2'b10)        check("R8 ptr after msg", 32'(ptr_rd), 32'(exp_ptr));
        else                         check("R5 ptr after msg", 32'(ptr_rd), 32'(exp_ptr));
        check("R5 idle after end", 32'(msg_busy), 32'd0);
    endtask

    initial begin
        exp_ptr = '0;
        repeat (2) @(negedge clk);
        check("R1 reset ptr", 32'(ptr_rd), 32'd0);
        check("R1 reset busy", 32'(msg_busy), 32'd0);
        check("R1 reset addr", 32'(word_addr), 32'd0);
        rst_n = 1'b1;

        // sweep mode x direction x validity with varying lengths
        for (int idx = 0; idx < 16; idx++) begin
            host_load(PTR_W'(16'h1000 + idx * 16'h0160));
            run_msg(2'(idx >> 2), 2'(idx >> 2), idx[1], idx[0], (idx * 5) % 41, 1'b0);
        end

        // R5: back-to-back valid swaps return to the start value
        host_load(16'h4A40);
        run_msg(2'b10, 2'b10, 1'b1, 1'b1, 32, 1'b0);
        run_msg(2'b10, 2'b10, 1'b1, 1'b1, 33, 1'b0);
        check("R5 double swap restores", 32'(ptr_rd), 32'h4A40);

        // R9: mode change mid-message has no effect
        host_load(16'h2200);
        run_msg(2'b00, 2'b10, 1'b1, 1'b1, 3, 1'b0);
        check("R9 late double ignored", 32'(ptr_rd), 32'h2200);
        run_msg(2'b10, 2'b00, 1'b1, 1'b1, 3, 1'b0);
        check("R9 late single ignored", 32'(ptr_rd), 32'h2220);

        // R10: host write during a message
        host_load(16'h0F80);
        run_msg(2'b10, 2'b10, 1'b1, 1'b0, 2, 1'b1);
        check("R10 ptr kept", 32'(ptr_rd), 32'h0F80);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule